// File: doc/BRIEF.md
# ADC Register Configuration Sequencer

This block brings a high-speed dual-channel converter into a known operating state. When asked to start, it sends a fixed, ordered list of register writes to the converter over a three-wire serial control port: a serial clock, a serial data line and an active-low chip select. Each write is a single 32-bit frame. The frame holds a constant 12-bit header, then a 4-bit register address, then a 16-bit data value. The write values are built into the block. Software cannot change them.

The list ends with the calibration step. The block writes the calibration register with its start bit clear. It then keeps chip select high for a programmable number of system clocks. Finally it writes the same register again with the start bit set, which begins the converter's calibration. Surrounding logic pulses `start` and waits for `done`. While the list is being sent, `busy` is high.

The serial clock is the system clock divided by `CLK_DIV`. The device samples data on the rising edge of the serial clock. The block changes the data line only at falling edges.

Top module: `adc_cfg_sequencer`

## Requirements
- R1: Every frame is exactly 32 serial clock rising edges long, sent MSB first. Its layout is {12'h001 in bits 31:20, address in bits 19:16, data in bits 15:0}, and the device reads each bit on the rising edge of `sclk`.
- R2: The frame addresses go out in this order: 0x1, 0x9, 0x2, 0xA, 0x3, 0xB, 0xE, 0xF, 0x0, 0x0.
- R3: The data words are 0xB7FF for 0x1, 0x03FF for 0x9, 0x007F for 0x2 and 0xA, 0xE07F for 0x3 and 0xB, 0x00FF for 0xE, and 0x007F for 0xF.
- R4: The first write to address 0x0 carries 0x7FFF, so the calibration bit (bit 15) is 0. The second write to address 0x0 carries 0xFFFF, so that bit is 1.
- R5: Between the two calibration frames, `cs_n` stays high for exactly `WAIT_CYCLES` system clocks (default 1280).
- R6: Between any other two consecutive frames, `cs_n` stays high for exactly 2*`CLK_DIV` system clocks.
- R7: `sclk` has a period of `CLK_DIV` system clocks and is low whenever `cs_n` is high. `sdata` never changes while `sclk` is high.
- R8: `cs_n` falls `CLK_DIV` + `CLK_DIV`/2 clocks before the first rising edge of `sclk`. It rises `CLK_DIV` clocks after the last falling edge of `sclk`.
- R9: `busy` is high from the cycle after an accepted `start` until the cycle in which `cs_n` rises after the final frame. In the next cycle `done` is high for exactly one cycle and `busy` is low.
- R10: A `start` that arrives while `busy` is high is ignored: it adds no frames and does not restart the list.
- R11: After reset, `cs_n` is 1 and `sclk`, `sdata`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send the configuration list |
| busy | output | 1 | High while the list is being sent |
| done | output | 1 | One-cycle pulse after the final frame |
| sclk | output | 1 | Serial clock to the converter |
| sdata | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench decodes every frame at the device's sampling edge. It measures, in system clocks, each chip-select-high interval, and so catches a wait counter that is off by one, or a long wait placed after the wrong frame. It measures the lead and tail around each frame and the spacing of serial clock edges, so a data change on the wrong edge or a missing lead period shows up as wrong bits or wrong intervals. It sends a second `start` mid-sequence, which would show as extra or repeated frames if the request leaked through. It also checks that `done` comes exactly one cycle after the last chip select rise and that the list can be run a second time.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

    localparam int FRAME_W    = 32;
    localparam int HDR_W      = 12;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 16;
    localparam int NUM_WRITES = 10;
    localparam int IDX_W      = $clog2(NUM_WRITES);
    localparam int BIT_W      = $clog2(FRAME_W);

    localparam logic [HDR_W-1:0] FRAME_HDR = 12'h001;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_write_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LEAD,
        SH_BITS,
        SH_TAIL
    } shift_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_SEND,
        SQ_HOLD
    } seq_state_t;

    // Ordered configuration list; the last two entries form the calibration pair.
    function automatic reg_write_t write_entry(input logic [IDX_W-1:0] idx);
        reg_write_t w;
        case (idx)
            4'd0:    w = '{addr: 4'h1, data: 16'hB7FF};
            4'd1:    w = '{addr: 4'h9, data: 16'h03FF};
            4'd2:    w = '{addr: 4'h2, data: 16'h007F};
            4'd3:    w = '{addr: 4'hA, data: 16'h007F};
            4'd4:    w = '{addr: 4'h3, data: 16'hE07F};
            4'd5:    w = '{addr: 4'hB, data: 16'hE07F};
            4'd6:    w = '{addr: 4'hE, data: 16'h00FF};
            4'd7:    w = '{addr: 4'hF, data: 16'h007F};
            4'd8:    w = '{addr: 4'h0, data: 16'h7FFF};
            4'd9:    w = '{addr: 4'h0, data: 16'hFFFF};
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic logic [FRAME_W-1:0] make_frame(input reg_write_t w);
        return {FRAME_HDR, w.addr, w.data};
    endfunction

endpackage

// File: rtl/cfg_table.sv
module cfg_table
    import adc_cfg_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    output logic [FRAME_W-1:0] frame,
    output logic               is_cal_clear,
    output logic               is_last
);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_WRITES - 1);
    localparam logic [IDX_W-1:0] CLEAR_IDX = IDX_W'(NUM_WRITES - 2);

    always_comb begin
        frame        = make_frame(write_entry(idx));
        is_cal_clear = (idx == CLEAR_IDX);
        is_last      = (idx == LAST_IDX);
    end

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic             expired
);

    logic             active;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            remain <= '0;
        end else if (load) begin
            active <= 1'b1;
            remain <= count;
        end else if (active) begin
            if (remain == '0) begin
                active <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign expired = active && (remain == '0);

    // R5: expiry is a single-cycle event per load
    a_r5_expire_once: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> !expired);

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import adc_cfg_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               ready,
    output logic               frame_done,
    output logic               sclk,
    output logic               sdata,
    output logic               cs_n
);

    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CLK_DIV / 2);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    shift_state_t       state, n_state;
    logic [CNT_W-1:0]   cnt, n_cnt;
    logic [BIT_W-1:0]   bit_idx, n_bit_idx;
    logic [FRAME_W-1:0] shreg, n_shreg;
    logic               n_done;

    always_comb begin
        n_state   = state;
        n_cnt     = cnt;
        n_bit_idx = bit_idx;
        n_shreg   = shreg;
        n_done    = 1'b0;
        case (state)
            SH_IDLE: begin
                if (load) begin
                    n_state   = SH_LEAD;
                    n_cnt     = '0;
                    n_bit_idx = '0;
                    n_shreg   = frame;
                end
            end
            SH_LEAD: begin
                if (cnt == CNT_LAST) begin
                    n_state = SH_BITS;
                    n_cnt   = '0;
                end else begin
                    n_cnt = cnt + 1'b1;
                end
            end
            SH_BITS: begin
                if (cnt == CNT_LAST) begin
                    n_cnt = '0;
                    if (bit_idx == BIT_LAST) begin
                        n_state = SH_TAIL;
                    end else begin
                        n_bit_idx = bit_idx + 1'b1;
                        n_shreg   = {shreg[FRAME_W-2:0], 1'b0};
                    end
                end else begin
                    n_cnt = cnt + 1'b1;
                end
            end
            SH_TAIL: begin
                if (cnt == CNT_LAST) begin
                    n_state = SH_IDLE;
                    n_cnt   = '0;
                    n_done  = 1'b1;
                end else begin
                    n_cnt = cnt + 1'b1;
                end
            end
            default: n_state = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SH_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            cs_n       <= 1'b1;
            sclk       <= 1'b0;
            sdata      <= 1'b0;
        end else begin
            state      <= n_state;
            cnt        <= n_cnt;
            bit_idx    <= n_bit_idx;
            shreg      <= n_shreg;
            frame_done <= n_done;
            cs_n       <= (n_state == SH_IDLE);
            sclk       <= (n_state == SH_BITS) && (n_cnt >= CNT_HALF);
            sdata      <= (n_state == SH_BITS) ? n_shreg[FRAME_W-1] : 1'b0;
        end
    end

    assign ready = (state == SH_IDLE);

    // R7: serial clock rests low whenever the device is deselected
    a_r7_sclk_low_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R7: data holds still across a high serial clock phase
    a_r7_sdata_steady_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> (sdata == $past(sdata)));

    // R1: a new frame is only accepted while idle
    a_r1_load_when_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> cs_n);

endmodule

// File: rtl/adc_cfg_sequencer.sv
module adc_cfg_sequencer
    import adc_cfg_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int WAIT_CYCLES = 1280
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic sclk,
    output logic sdata,
    output logic cs_n
);

    localparam int GAP_CYCLES = 2 * CLK_DIV;
    localparam int HOLD_MAX   = (WAIT_CYCLES > GAP_CYCLES) ? WAIT_CYCLES : GAP_CYCLES;
    localparam int HOLD_W     = $clog2(HOLD_MAX + 1);
    // Three cycles of the chip-select-high interval are spent in handoff:
    // serializer done flag, timer expiry decision and the issue cycle.
    localparam int HANDOFF    = 3;
    localparam logic [HOLD_W-1:0] HOLD_GAP  = HOLD_W'(GAP_CYCLES - HANDOFF);
    localparam logic [HOLD_W-1:0] HOLD_CAL  = HOLD_W'(WAIT_CYCLES - HANDOFF);

    seq_state_t         state;
    logic [IDX_W-1:0]   idx;
    logic [FRAME_W-1:0] cur_frame;
    logic               is_cal_clear;
    logic               is_last;
    logic               tx_load;
    logic               tx_ready;
    logic               tx_done;
    logic               t_load;
    logic [HOLD_W-1:0]  t_count;
    logic               t_expired;

    cfg_table u_table (
        .idx          (idx),
        .frame        (cur_frame),
        .is_cal_clear (is_cal_clear),
        .is_last      (is_last)
    );

    frame_serializer #(
        .CLK_DIV (CLK_DIV)
    ) u_ser (
        .clk        (clk),
        .rst        (rst),
        .load       (tx_load),
        .frame      (cur_frame),
        .ready      (tx_ready),
        .frame_done (tx_done),
        .sclk       (sclk),
        .sdata      (sdata),
        .cs_n       (cs_n)
    );

    hold_timer #(
        .CNT_W (HOLD_W)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .count   (t_count),
        .expired (t_expired)
    );

    assign tx_load = (state == SQ_ISSUE) && tx_ready;
    assign t_load  = (state == SQ_SEND) && tx_done && !is_last;
    assign t_count = is_cal_clear ? HOLD_CAL : HOLD_GAP;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            idx   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state <= SQ_ISSUE;
                        idx   <= '0;
                        busy  <= 1'b1;
                    end
                end
                SQ_ISSUE: begin
                    if (tx_ready) begin
                        state <= SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    if (tx_done) begin
                        if (is_last) begin
                            state <= SQ_IDLE;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                        end else begin
                            state <= SQ_HOLD;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (t_expired) begin
                        idx   <= idx + 1'b1;
                        state <= SQ_ISSUE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R9: completion is a one-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: completion is reported only once the sequence is no longer busy
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: the device is selected only within a busy sequence
    a_r9_select_within_busy: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    // R10: a sequence begins only in answer to a start request
    a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R2: the list index stays inside the table
    a_r2_index_in_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx < IDX_W'(NUM_WRITES)));

endmodule

// File: tb/adc_cfg_sequencer_test.sv
module adc_cfg_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int WAITC      = 1280;
    localparam int NFR        = 10;
    localparam int MAXF       = 24;
    localparam int LIMIT      = 20000;

    // R1..R4: expected frames {header 0x001, address, data}
    localparam logic [31:0] EXP_FRAMES [NFR] = '{
        32'h0011B7FF, 32'h001903FF, 32'h0012007F, 32'h001A007F, 32'h0013E07F,
        32'h001BE07F, 32'h001E00FF, 32'h001F007F, 32'h00107FFF, 32'h0010FFFF
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, sclk, sdata, cs_n;

    int errors = 0;
    int checks = 0;

    adc_cfg_sequencer #(.CLK_DIV(DIV), .WAIT_CYCLES(WAITC)) uut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .sclk(sclk), .sdata(sdata), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor sampling at the falling system clock edge
    logic [31:0] cap_frame [MAXF];
    int cap_bits [MAXF];
    int fall_t [MAXF];
    int rise_t [MAXF];
    int lead_t [MAXF];
    int tail_t [MAXF];
    logic busy_at_rise [MAXF];
    int nf = 0;
    int nbits = 0;
    logic [31:0] shreg = '0;
    int last_sfall = 0;
    int last_srise = -1;
    int period_err = 0;
    int glitch_err = 0;
    int idle_err = 0;
    int done_cnt = 0;
    int done_t = 0;
    logic mon_en = 1'b0;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_sdata = 1'b0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (p_cs && !cs_n && nf < MAXF) begin
                fall_t[nf] = cyc;
                nbits = 0;
                shreg = '0;
                last_srise = -1;
            end
            if (!p_sclk && sclk) begin
                if (nbits == 0 && nf < MAXF) lead_t[nf] = cyc - fall_t[nf];
                if (last_srise >= 0 && (cyc - last_srise) != DIV) period_err++;
                last_srise = cyc;
                shreg = {shreg[30:0], sdata};
                nbits++;
            end
            if (p_sclk && !sclk) last_sfall = cyc;
            if (p_sclk && sclk && (sdata !== p_sdata)) glitch_err++;
            if (cs_n && sclk) idle_err++;
            if (!p_cs && cs_n && nf < MAXF) begin
                cap_frame[nf] = shreg;
                cap_bits[nf] = nbits;
                rise_t[nf] = cyc;
                tail_t[nf] = cyc - last_sfall;
                busy_at_rise[nf] = busy;
                nf++;
            end
            if (done) begin
                done_cnt++;
                done_t = cyc;
            end
        end
        p_cs = cs_n;
        p_sclk = sclk;
        p_sdata = sdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    bit timed_out = 1'b0;

    task automatic wait_done();
        int n = 0;
        while (!done && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            timed_out = 1'b1;
            chk(1'b0, "watchdog", 32'(n), 32'(LIMIT));
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_run(input int base);
        for (int i = 0; i < NFR; i++) begin
            int f = base + i;
            chk(cap_frame[f] == EXP_FRAMES[i], "R1 R2 R3 R4 frame content", cap_frame[f], EXP_FRAMES[i]);
            chk(cap_bits[f] == 32, "R1 bit count", 32'(cap_bits[f]), 32);
            chk(lead_t[f] == DIV + DIV/2, "R8 lead", 32'(lead_t[f]), 32'(DIV + DIV/2));
            chk(tail_t[f] == DIV, "R8 tail", 32'(tail_t[f]), 32'(DIV));
            if (i > 0) begin
                int gap = fall_t[f] - rise_t[f-1];
                if (i == NFR - 1)
                    chk(gap == WAITC, "R5 calibration wait", 32'(gap), 32'(WAITC));
                else
                    chk(gap == 2*DIV, "R6 inter-frame gap", 32'(gap), 32'(2*DIV));
            end
        end
        chk(cap_frame[base+8][15] == 1'b0, "R4 cal bit clear", 32'(cap_frame[base+8][15]), 0);
        chk(cap_frame[base+9][15] == 1'b1, "R4 cal bit set", 32'(cap_frame[base+9][15]), 1);
        chk(busy_at_rise[base+NFR-1] == 1'b1, "R9 busy through last frame", 32'(busy_at_rise[base+NFR-1]), 1);
        chk(done_t == rise_t[base+NFR-1] + 1, "R9 done timing", 32'(done_t), 32'(rise_t[base+NFR-1] + 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(cs_n == 1'b1, "R11 cs_n", 32'(cs_n), 1);
        chk(sclk == 1'b0, "R11 sclk", 32'(sclk), 0);
        chk(sdata == 1'b0, "R11 sdata", 32'(sdata), 0);
        chk(busy == 1'b0, "R11 busy", 32'(busy), 0);
        chk(done == 1'b0, "R11 done", 32'(done), 0);
        rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);

        // First run, with a stray start mid-sequence (R10)
        pulse_start();
        chk(busy == 1'b1, "R9 busy after start", 32'(busy), 1);
        repeat (300) @(negedge clk);
        pulse_start();
        chk(busy == 1'b1, "R10 still busy", 32'(busy), 1);
        wait_done();
        if (!timed_out) begin
            chk(busy == 1'b0, "R9 busy low with done", 32'(busy), 0);
            @(negedge clk);
            chk(done == 1'b0, "R9 done one cycle", 32'(done), 0);
            repeat (50) @(negedge clk);
            chk(nf == NFR, "R10 frame count", 32'(nf), 32'(NFR));
            chk(done_cnt == 1, "R10 done count", 32'(done_cnt), 1);
            chk(busy == 1'b0 && cs_n == 1'b1, "R10 no restart", {30'd0, busy, cs_n}, 32'd1);
            check_run(0);

            // Second run from idle
            pulse_start();
            wait_done();
            if (!timed_out) begin
                repeat (5) @(negedge clk);
                chk(nf == 2*NFR, "R2 second run count", 32'(nf), 32'(2*NFR));
                check_run(NFR);
            end
        end
        chk(period_err == 0, "R7 sclk period", 32'(period_err), 0);
        chk(glitch_err == 0, "R7 sdata change while sclk high", 32'(glitch_err), 0);
        chk(idle_err == 0, "R7 sclk high while deselected", 32'(idle_err), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule